// File: doc/BRIEF.md
# Tester Pin Channel Formatter

This block models a single pin of a digital tester. Time is divided into tester cycles, and each cycle is made up of a fixed number of sub-cycle ticks. One clock of the block equals one tick. For each tester cycle the block takes one vector symbol, a data format and three timing settings. The timing settings are a data-window start tick, a data-window end tick and a strobe tick. They come from a shared timing generator and are applied to the whole cycle.

A drive symbol makes the block shape a waveform on the pin model's drive value and enable. The shape follows the selected format: non-return-to-zero, return-to-zero, return-to-one or surround-by-complement. An expect symbol releases the pin instead. The block then samples the pin input once, at the strobe tick, and reports a miscompare against the expected level. A sticky fail flag keeps the number of the first tester cycle that failed.

The symbol, format and timing values present during the last tick of a cycle govern the next cycle.

Top module: `pin_fmt_channel`

## Requirements
- R1: `vec_sym` codes are: 0 = drive low, 1 = drive high, 2 = expect low, 3 = expect high, 4 = no drive and no compare. Codes 5 to 7 behave exactly like code 4.
- R2: `pin_oe` is high for every tick of a cycle whose symbol is a drive code (0 or 1) and low for every tick otherwise. Whenever `pin_oe` is low, `pin_drv` is 0.
- R3: Format code 0 (non-return-to-zero) drives the data bit (symbol bit 0) on all ticks of the cycle.
- R4: Format code 1 (return-to-zero) drives the data on ticks t with start <= t <= end and drives 0 on every other tick. When start > end the window is empty.
- R5: Format code 2 (return-to-one) drives the data inside the window and 1 outside it.
- R6: Format code 3 (surround-by-complement) drives the data inside the window and the inverted data before and after it.
- R7: A tester cycle lasts TICKS clocks. The inputs are captured on the clock edge that ends the last tick and hold for the entire next cycle. The waveform value of tick t is on the pins during the clock period that follows the edge entering tick t.
- R8: For an expect symbol, `pin_in` is sampled on the clock edge that ends the strobe tick. If it differs from the expected level (symbol bit 0), `mis_o` is high for exactly the following clock. Drive and no-compare symbols never raise `mis_o`, whatever the level on `pin_in`.
- R9: The first miscompare sets `fail_o`, which then stays high. The same miscompare loads `fail_cyc` with the number of the cycle that failed, and later miscompares leave it unchanged. Cycle 0 is the cycle that begins at reset. A miscompare at the last tick records the cycle that is ending, not the one that is starting.
- R10: Synchronous active-high reset clears `pin_drv`, `pin_oe`, `mis_o`, `fail_o` and `fail_cyc`. Cycle 0 after reset behaves as a no-compare cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_sym | input | 3 | Vector symbol for the next cycle |
| fmt_sel | input | 2 | Drive format for the next cycle |
| win_start | input | TICK_W | First tick of the data window |
| win_end | input | TICK_W | Last tick of the data window |
| strobe_at | input | TICK_W | Tick at which an expected level is compared |
| pin_in | input | 1 | Level observed on the pin |
| pin_drv | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Drive enable for the pin |
| mis_o | output | 1 | One-clock miscompare pulse |
| fail_o | output | 1 | Sticky fail flag |
| fail_cyc | output | CYC_W | Number of the first failing cycle |

## Verification
A strobe placed on the last tick makes the compare happen on the same clock edge that loads the next cycle's symbol and advances the cycle count. The bench provokes this with an expect cycle whose strobe is 15. It does so once, after an earlier failure, to check that the held cycle number does not move. It does so again just after a fresh reset, where the recorded number must be that of the ending cycle (1), not the new one. Because the miscompare pulse then appears in the first tick of the following cycle, the bench credits every pulse seen on that first tick to the cycle that just ended.

// File: rtl/pin_fmt_pkg.sv
package pin_fmt_pkg;

  typedef enum logic [2:0] {
    SYM_DRV0 = 3'd0,
    SYM_DRV1 = 3'd1,
    SYM_EXPL = 3'd2,
    SYM_EXPH = 3'd3,
    SYM_NONE = 3'd4
  } sym_e;

  typedef enum logic [1:0] {
    FMT_NRZ = 2'd0,
    FMT_RTZ = 2'd1,
    FMT_RTO = 2'd2,
    FMT_SBC = 2'd3
  } fmt_e;

  function automatic logic sym_is_drive(input logic [2:0] s);
    return (s == SYM_DRV0) || (s == SYM_DRV1);
  endfunction

  function automatic logic sym_is_expect(input logic [2:0] s);
    return (s == SYM_EXPL) || (s == SYM_EXPH);
  endfunction

endpackage

// File: rtl/pin_cycle_timer.sv
module pin_cycle_timer #(
  parameter int TICKS  = 16,
  parameter int CYC_W  = 16,
  parameter int TICK_W = $clog2(TICKS)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [TICK_W-1:0] tick_q,
  output logic [TICK_W-1:0] tick_nxt,
  output logic              wrap,
  output logic [CYC_W-1:0]  cyc_q
);

  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(TICKS - 1);

  always_comb begin
    wrap     = (tick_q == LAST_TICK);
    tick_nxt = wrap ? '0 : tick_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
      cyc_q  <= '0;
    end else begin
      tick_q <= tick_nxt;
      if (wrap) cyc_q <= cyc_q + 1'b1;
    end
  end

endmodule

// File: rtl/pin_wave_gen.sv
module pin_wave_gen
  import pin_fmt_pkg::*;
#(
  parameter int TICK_W = 4
) (
  input  logic [TICK_W-1:0] tick,
  input  logic [TICK_W-1:0] win_lo,
  input  logic [TICK_W-1:0] win_hi,
  input  logic [2:0]        sym,
  input  fmt_e              fmt,
  output logic              drv,
  output logic              oe
);

  logic data_bit;
  logic in_win;

  always_comb begin
    data_bit = sym[0];
    in_win   = (tick >= win_lo) && (tick <= win_hi);
    oe       = sym_is_drive(sym);
    case (fmt)
      FMT_NRZ: drv = data_bit;
      FMT_RTZ: drv = in_win ? data_bit : 1'b0;
      FMT_RTO: drv = in_win ? data_bit : 1'b1;
      FMT_SBC: drv = in_win ? data_bit : ~data_bit;
      default: drv = data_bit;
    endcase
    if (!oe) drv = 1'b0;
  end

endmodule

// File: rtl/pin_strobe_cmp.sv
module pin_strobe_cmp
  import pin_fmt_pkg::*;
#(
  parameter int TICK_W = 4,
  parameter int CYC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TICK_W-1:0] tick,
  input  logic [TICK_W-1:0] strobe,
  input  logic [2:0]        sym,
  input  logic              pin_in,
  input  logic [CYC_W-1:0]  cyc,
  output logic              mis_o,
  output logic              fail_o,
  output logic [CYC_W-1:0]  fail_cyc_o
);

  logic hit;

  always_comb begin
    hit = sym_is_expect(sym) && (tick == strobe) && (pin_in != sym[0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mis_o      <= 1'b0;
      fail_o     <= 1'b0;
      fail_cyc_o <= '0;
    end else begin
      mis_o <= hit;
      if (hit && !fail_o) begin
        fail_o     <= 1'b1;
        fail_cyc_o <= cyc;
      end
    end
  end

endmodule

// File: rtl/pin_fmt_channel.sv
module pin_fmt_channel
  import pin_fmt_pkg::*;
#(
  parameter int TICKS  = 16,
  parameter int CYC_W  = 16,
  parameter int TICK_W = $clog2(TICKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        vec_sym,
  input  logic [1:0]        fmt_sel,
  input  logic [TICK_W-1:0] win_start,
  input  logic [TICK_W-1:0] win_end,
  input  logic [TICK_W-1:0] strobe_at,
  input  logic              pin_in,
  output logic              pin_drv,
  output logic              pin_oe,
  output logic              mis_o,
  output logic              fail_o,
  output logic [CYC_W-1:0]  fail_cyc
);

  logic [TICK_W-1:0] tick_q, tick_nxt;
  logic              wrap;
  logic [CYC_W-1:0]  cyc_q;

  logic [2:0]        sym_q, sym_nxt;
  fmt_e              fmt_q, fmt_nxt;
  logic [TICK_W-1:0] ws_q, ws_nxt, we_q, we_nxt, st_q, st_nxt;
  logic              drv_nxt, oe_nxt;

  pin_cycle_timer #(.TICKS(TICKS), .CYC_W(CYC_W), .TICK_W(TICK_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .tick_q   (tick_q),
    .tick_nxt (tick_nxt),
    .wrap     (wrap),
    .cyc_q    (cyc_q)
  );

  // Cycle settings change only at the cycle boundary.
  always_comb begin
    sym_nxt = wrap ? vec_sym         : sym_q;
    fmt_nxt = wrap ? fmt_e'(fmt_sel) : fmt_q;
    ws_nxt  = wrap ? win_start       : ws_q;
    we_nxt  = wrap ? win_end         : we_q;
    st_nxt  = wrap ? strobe_at       : st_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_q <= SYM_NONE;
      fmt_q <= FMT_NRZ;
      ws_q  <= '0;
      we_q  <= '0;
      st_q  <= '0;
    end else begin
      sym_q <= sym_nxt;
      fmt_q <= fmt_nxt;
      ws_q  <= ws_nxt;
      we_q  <= we_nxt;
      st_q  <= st_nxt;
    end
  end

  // Waveform is computed for the tick being entered so the registered pins line up with tick_q.
  pin_wave_gen #(.TICK_W(TICK_W)) u_wave (
    .tick   (tick_nxt),
    .win_lo (ws_nxt),
    .win_hi (we_nxt),
    .sym    (sym_nxt),
    .fmt    (fmt_nxt),
    .drv    (drv_nxt),
    .oe     (oe_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_drv <= 1'b0;
      pin_oe  <= 1'b0;
    end else begin
      pin_drv <= drv_nxt;
      pin_oe  <= oe_nxt;
    end
  end

  pin_strobe_cmp #(.TICK_W(TICK_W), .CYC_W(CYC_W)) u_cmp (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick_q),
    .strobe     (st_q),
    .sym        (sym_q),
    .pin_in     (pin_in),
    .cyc        (cyc_q),
    .mis_o      (mis_o),
    .fail_o     (fail_o),
    .fail_cyc_o (fail_cyc)
  );

endmodule

// File: rtl/pin_fmt_channel_chk.sv
module pin_fmt_channel_chk #(
  parameter int TICK_W = 4,
  parameter int CYC_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [TICK_W-1:0] tick_q,
  input logic [1:0]        fmt_q,
  input logic              pin_drv,
  input logic              pin_oe,
  input logic              mis_o,
  input logic              fail_o,
  input logic [CYC_W-1:0]  fail_cyc
);

  assert_undriven_low_R2: assert property (@(posedge clk) disable iff (rst)
    !pin_oe |-> !pin_drv);

  assert_nrz_steady_R3: assert property (@(posedge clk) disable iff (rst)
    (pin_oe && fmt_q == 2'd0 && tick_q != '0) |-> $stable(pin_drv));

  assert_mis_sets_fail_R8: assert property (@(posedge clk) disable iff (rst)
    mis_o |-> fail_o);

  assert_mis_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    mis_o |=> !mis_o);

  assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    fail_o |=> fail_o);

  assert_fail_cyc_held_R9: assert property (@(posedge clk) disable iff (rst)
    fail_o |=> $stable(fail_cyc));

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (!fail_o && !pin_oe && !mis_o && fail_cyc == '0));

endmodule

bind pin_fmt_channel pin_fmt_channel_chk #(.TICK_W(TICK_W), .CYC_W(CYC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_q   (tick_q),
  .fmt_q    (fmt_q),
  .pin_drv  (pin_drv),
  .pin_oe   (pin_oe),
  .mis_o    (mis_o),
  .fail_o   (fail_o),
  .fail_cyc (fail_cyc)
);

// File: tb/sim_pin_fmt_channel.sv
`timescale 1ns/1ps
module sim_pin_fmt_channel;

  localparam int TICKS = 16;
  localparam int TW    = 4;
  localparam int CW    = 16;
  localparam int NV    = 13;
  // Vector fields: {fmt[17:16], sym[15:13], start[12:9], end[8:5], strobe[4:1], pin level[0]}
  localparam logic [17:0] IDLE = {2'd0, 3'd4, 4'd0, 4'd0, 4'd0, 1'b0};
  localparam logic [17:0] TAB [NV] = '{
    {2'd0, 3'd1, 4'd0, 4'd15, 4'd0,  1'b0},  // R3 NRZ high
    {2'd1, 3'd1, 4'd4, 4'd10, 4'd0,  1'b0},  // R4 RTZ window
    {2'd2, 3'd0, 4'd2, 4'd6,  4'd0,  1'b0},  // R5 RTO low data
    {2'd3, 3'd1, 4'd5, 4'd9,  4'd0,  1'b0},  // R6 SBC high data
    {2'd3, 3'd0, 4'd0, 4'd3,  4'd0,  1'b0},  // R6 SBC low data at cycle start
    {2'd1, 3'd1, 4'd9, 4'd3,  4'd0,  1'b0},  // R4 empty window
    {2'd0, 3'd3, 4'd0, 4'd0,  4'd7,  1'b0},  // R8 expect high, sees low
    {2'd0, 3'd2, 4'd0, 4'd0,  4'd3,  1'b0},  // R8 expect low, passes
    {2'd1, 3'd4, 4'd2, 4'd8,  4'd4,  1'b1},  // R1 no compare
    {2'd3, 3'd6, 4'd2, 4'd8,  4'd4,  1'b1},  // R1 code 6 acts as no compare
    {2'd0, 3'd2, 4'd0, 4'd0,  4'd15, 1'b1},  // R9 miscompare on last tick after first fail
    {2'd0, 3'd0, 4'd0, 4'd15, 4'd5,  1'b1},  // R8 drive ignores pin level
    {2'd2, 3'd3, 4'd1, 4'd4,  4'd0,  1'b1}   // R8 expect high at tick 0, passes
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    vec_sym = 3'd4;
  logic [1:0]    fmt_sel = 2'd0;
  logic [TW-1:0] win_start = '0, win_end = '0, strobe_at = '0;
  logic          ext_lvl = 1'b0;
  logic          pin_drv, pin_oe, mis_o, fail_o;
  logic [CW-1:0] fail_cyc;

  int checks = 0;
  int fails  = 0;
  logic          fail_m;
  logic [CW-1:0] fcyc_m;

  always #2 clk = ~clk;

  pin_fmt_channel #(.TICKS(TICKS), .CYC_W(CW)) u0 (
    .clk(clk), .rst(rst), .vec_sym(vec_sym), .fmt_sel(fmt_sel),
    .win_start(win_start), .win_end(win_end), .strobe_at(strobe_at),
    .pin_in(ext_lvl), .pin_drv(pin_drv), .pin_oe(pin_oe),
    .mis_o(mis_o), .fail_o(fail_o), .fail_cyc(fail_cyc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [17:0] v);
    {fmt_sel, vec_sym, win_start, win_end, strobe_at} = v[17:1];
  endtask

  function automatic logic exp_drv(input logic [17:0] v, input int t);
    logic [2:0] s;
    logic d, inw;
    s = v[15:13];
    if (s > 3'd1) return 1'b0;
    d   = s[0];
    inw = (t >= int'(v[12:9])) && (t <= int'(v[8:5]));
    case (v[17:16])
      2'd0: return d;
      2'd1: return inw ? d : 1'b0;
      2'd2: return inw ? d : 1'b1;
      default: return inw ? d : ~d;
    endcase
  endfunction

  // Reset, then run cycle 0 while the first vector waits; return at tick 0 of cycle 1.
  task automatic boot(input logic [17:0] first);
    int oe_cnt;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk(pin_drv == 1'b0 && pin_oe == 1'b0, "R10 pins after reset", {pin_drv, pin_oe}, 0);
    chk(fail_o == 1'b0 && mis_o == 1'b0, "R10 flags after reset", {fail_o, mis_o}, 0);
    chk(fail_cyc == '0, "R10 fail_cyc after reset", int'(fail_cyc), 0);
    apply(first);
    fail_m = 1'b0;
    fcyc_m = '0;
    oe_cnt = 0;
    repeat (15) begin
      @(posedge clk); #1;
      oe_cnt += int'(pin_oe);
    end
    @(posedge clk); #1;
    chk(oe_cnt == 0, "R10 cycle 0 undriven", oe_cnt, 0);
  endtask

  // Entered at tick 0 of a cycle; returns at tick 0 of the next one.
  task automatic do_cycle(input logic [17:0] v, input logic [17:0] nv, input int cyc);
    logic [15:0] dp, op, edp, eop;
    int seen;
    logic emis;
    string rtag;
    dp[0] = pin_drv;
    op[0] = pin_oe;
    ext_lvl = v[0];
    apply(nv);
    seen = 0;
    for (int t = 1; t < TICKS; t++) begin
      @(posedge clk); #1;
      dp[t] = pin_drv;
      op[t] = pin_oe;
      seen += int'(mis_o);
    end
    @(posedge clk); #1;
    seen += int'(mis_o);
    for (int t = 0; t < TICKS; t++) begin
      edp[t] = exp_drv(v, t);
      eop[t] = (v[15:13] <= 3'd1);
    end
    emis = (v[15:13] == 3'd2 || v[15:13] == 3'd3) && (v[0] != v[13]);
    if (emis && !fail_m) begin
      fail_m = 1'b1;
      fcyc_m = CW'(cyc);
    end
    case (v[17:16])
      2'd0:    rtag = "R3";
      2'd1:    rtag = "R4";
      2'd2:    rtag = "R5";
      default: rtag = "R6";
    endcase
    if (v[15:13] > 3'd1) rtag = "R2";
    chk(dp == edp, $sformatf("%s R7 drive pattern cycle %0d", rtag, cyc), int'(dp), int'(edp));
    chk(op == eop, $sformatf("R1 R2 enable pattern cycle %0d", cyc), int'(op), int'(eop));
    chk(seen == int'(emis), $sformatf("R8 miscompare pulses cycle %0d", cyc), seen, int'(emis));
    chk(fail_o == fail_m, $sformatf("R9 fail flag cycle %0d", cyc), int'(fail_o), int'(fail_m));
    chk(fail_cyc == fcyc_m, $sformatf("R9 fail cycle number cycle %0d", cyc), int'(fail_cyc), int'(fcyc_m));
  endtask

  initial begin
    boot(TAB[0]);
    for (int i = 0; i < NV; i++) begin
      do_cycle(TAB[i], (i < NV - 1) ? TAB[i + 1] : IDLE, i + 1);
    end
    // Directed: reset clears the earlier failure; strobe on the last tick records the ending cycle.
    boot({2'd0, 3'd3, 4'd0, 4'd0, 4'd15, 1'b0});
    do_cycle({2'd0, 3'd3, 4'd0, 4'd0, 4'd15, 1'b0}, {2'd1, 3'd2, 4'd0, 4'd0, 4'd2, 1'b1}, 1);
    chk(fail_cyc == CW'(1), "R9 boundary strobe records ending cycle", int'(fail_cyc), 1);
    do_cycle({2'd1, 3'd2, 4'd0, 4'd0, 4'd2, 1'b1}, IDLE, 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule